// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block sits between a prefetch address generator and the memory side of a cache. After a demand miss, the generator produces prefetch candidates one at a time. Each candidate carries an address and a delay. The block keeps the candidates in a bounded first-in-first-out queue and stamps each one with a ready time. Three rules keep the queue free of useless work:

- Duplicate candidates are dropped.
- An entry is withdrawn when a later demand miss touches its block.
- In serial-squash mode, younger work is discarded from the tail when a fresh miss arrives.

When the memory side asks for a prefetch, the block checks the head entry against the cache tags and the outstanding-miss registers. This check is a one-cycle lookup handshake. The block skips heads that are already cached or already pending, and hands out the first head that passes.

All address comparisons are made on block addresses, formed by clearing the low log2(block size) bits. A flag tells the bus arbiter whether the queue holds anything. The ready time of the head entry is reported continuously. Seven event counters record what happened to each candidate and each issue.

Top module: `pfq_manager`

## Requirements
- R1: Deduplication and cancellation compare block addresses only; two addresses that differ only in their low log2(BLK_BYTES) bits count as the same entry. Issued and looked-up addresses are block addresses, with those low bits cleared.
- R2: A miss notify with `miss_uncache` set is ignored. A miss notify with `miss_ifetch` set while `cfg_data_only` is high is also ignored. An ignored notify cancels nothing, squashes nothing and does not change the base time.
- R3: An accepted miss notify removes the queued entry whose block matches the miss block, if there is one, and adds one to `cnt_cancelled`.
- R4: When `cfg_serial_squash` is high, an accepted notify then removes tail entries one by one while the queue is non-empty and the tail ready time is greater than or equal to `miss_time`. Each removal adds one to `cnt_squashed`.
- R5: Every candidate taken in adds one to `cnt_identified`. A candidate whose block is already queued is dropped and adds one to `cnt_dup`, so the queue never holds two entries for one block.
- R6: An accepted candidate is appended at the tail. Its ready time is the `miss_time` of the last accepted notify plus `cand_delay`, modulo 2^TW; the base time is zero after reset.
- R7: A candidate arriving while the queue holds DEPTH entries first evicts the head entry and adds one to `cnt_evicted`. The queue never holds more than DEPTH entries.
- R8: `issue_req` is honoured in the idle state. The block raises `lkup_req` with the head block on `lkup_addr`, and samples `lkup_in_cache` and `lkup_in_mshr` one cycle later. If either is set, the head is discarded (`cnt_skipped` +1) and the next head is looked up. Otherwise the head is popped and shown on `issue_addr` with a one-cycle `issue_valid` pulse (`cnt_issued` +1). A one-cycle `issue_none` pulse answers a request that finds or leaves the queue empty. `issue_valid` and `issue_none` never coincide.
- R9: `pf_bus_req` is high exactly when the queue is non-empty.
- R10: `head_ready_time` shows the ready time of the head entry, or zero when the queue is empty.
- R11: An accepted notify has priority over the issue path. During a lookup it restarts the lookup on the current head. A candidate presented in the same cycle as an accepted notify is dropped uncounted.
- R12: Entries that pass the filters are issued in the order in which they were appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable tail squash on an accepted miss |
| miss_valid | input | 1 | Miss notify strobe |
| miss_addr | input | AW | Miss address |
| miss_time | input | TW | Miss timestamp |
| miss_uncache | input | 1 | Miss is uncacheable |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate strobe |
| cand_addr | input | AW | Candidate address |
| cand_delay | input | DW | Candidate delay |
| issue_req | input | 1 | Request for one prefetch |
| lkup_in_cache | input | 1 | Lookup response: block present in cache |
| lkup_in_mshr | input | 1 | Lookup response: block already pending |
| lkup_req | output | 1 | Lookup request strobe |
| lkup_addr | output | AW | Block looked up |
| issue_valid | output | 1 | Prefetch issued this cycle |
| issue_addr | output | AW | Issued block address |
| issue_none | output | 1 | No prefetch available |
| pf_bus_req | output | 1 | Memory-bus prefetch request |
| head_ready_time | output | TW | Ready time of the head entry |
| cnt_identified | output | CW | Candidates taken in |
| cnt_dup | output | CW | Candidates dropped as duplicates |
| cnt_evicted | output | CW | Head entries evicted by a full queue |
| cnt_cancelled | output | CW | Entries cancelled by a miss |
| cnt_squashed | output | CW | Entries squashed from the tail |
| cnt_issued | output | CW | Prefetches issued |
| cnt_skipped | output | CW | Heads skipped by the lookup filter |

## Verification
Any wrong entry in the queue reaches the ports within one cycle. A miscounted occupancy shows at once on `pf_bus_req`, and a wrong head shows at once on `head_ready_time`. A wrong order or a lost or stray entry shows at the next drain: the queue is emptied through the issue path with no lookup hits, so every queued block comes out in sequence on `issue_addr`. A wrong squash boundary or a stale lookup after a restart shows on the cycle-counted `lkup_req` pulses, and on the counter ports one cycle after the event.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_ISSUE  = 2'd2
  } pfq_state_e;

  // event counter slots
  localparam int EV_IDENT  = 0;
  localparam int EV_DUP    = 1;
  localparam int EV_EVICT  = 2;
  localparam int EV_CANCEL = 3;
  localparam int EV_SQUASH = 4;
  localparam int EV_ISSUED = 5;
  localparam int EV_SKIP   = 6;
  localparam int NUM_EV    = 7;

endpackage

// File: rtl/pfq_match.sv
// Parallel block-address compare of one key against every live entry.
module pfq_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic [AW-1:0]    key,
  input  logic [AW-1:0]    ents [DEPTH],
  input  logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = live[g] && (ents[g] == key);
  end
endmodule

// File: rtl/pfq_evcnt.sv
// Wrapping event counter that accepts multi-unit increments.
module pfq_evcnt #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en = (inc != '0);
  assign cnt_n  = cnt_q + CW'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pfq_store.sv
// Shift-compacted entry array: cancel, squash, pop, dedup, evict and append.
module pfq_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 32,
  parameter int DW    = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_squash,
  input  logic            note_acc,
  input  logic [AW-1:0]   note_blk,
  input  logic [TW-1:0]   note_time,
  input  logic            cand_take,
  input  logic [AW-1:0]   cand_blk,
  input  logic [DW-1:0]   cand_delay,
  input  logic            pop,
  output logic [AW-1:0]   head_blk,
  output logic [TW-1:0]   head_rdy,
  output logic [CNTW-1:0] q_count,
  output logic [CNTW-1:0] inc_ident,
  output logic [CNTW-1:0] inc_dup,
  output logic [CNTW-1:0] inc_evict,
  output logic [CNTW-1:0] inc_cancel,
  output logic [CNTW-1:0] inc_squash
);
  logic [AW-1:0]   blk_q [DEPTH];
  logic [TW-1:0]   rdy_q [DEPTH];
  logic [CNTW-1:0] cnt_q;
  logic [TW-1:0]   base_q;

  logic [AW-1:0]   a_blk [DEPTH];
  logic [TW-1:0]   a_rdy [DEPTH];
  logic [CNTW-1:0] a_cnt;
  logic [AW-1:0]   n_blk [DEPTH];
  logic [TW-1:0]   n_rdy [DEPTH];
  logic [CNTW-1:0] n_cnt;
  logic [TW-1:0]   base_n;

  logic [DEPTH-1:0] live_q, live_a, can_hit, dup_hit;
  logic [CNTW-1:0]  keep;
  logic [CNTW-1:0]  can_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign live_q[g] = CNTW'(g) < cnt_q;
    assign live_a[g] = CNTW'(g) < a_cnt;
  end

  pfq_match #(.DEPTH(DEPTH), .AW(AW)) u_cancel_cmp (
    .key(note_blk), .ents(blk_q), .live(live_q), .hit(can_hit)
  );

  // stage A: miss cancel, tail squash, issue pop
  always_comb begin
    a_blk      = blk_q;
    a_rdy      = rdy_q;
    a_cnt      = cnt_q;
    inc_cancel = '0;
    inc_squash = '0;
    can_idx    = '0;
    keep       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (can_hit[i]) can_idx = CNTW'(i);
    end
    if (note_acc && (can_hit != '0)) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (CNTW'(i) >= can_idx) begin
          a_blk[i] = blk_q[i+1];
          a_rdy[i] = rdy_q[i+1];
        end
      end
      a_cnt      = cnt_q - CNTW'(1);
      inc_cancel = CNTW'(1);
    end
    if (note_acc && cfg_squash) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((CNTW'(i) < a_cnt) && (a_rdy[i] < note_time)) keep = CNTW'(i + 1);
      end
      inc_squash = a_cnt - keep;
      a_cnt      = keep;
    end
    if (pop && (a_cnt != '0)) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        a_blk[i] = a_blk[i+1];
        a_rdy[i] = a_rdy[i+1];
      end
      a_cnt = a_cnt - CNTW'(1);
    end
  end

  pfq_match #(.DEPTH(DEPTH), .AW(AW)) u_dup_cmp (
    .key(cand_blk), .ents(a_blk), .live(live_a), .hit(dup_hit)
  );

  // stage B: candidate dedup, full eviction, append
  always_comb begin
    n_blk     = a_blk;
    n_rdy     = a_rdy;
    n_cnt     = a_cnt;
    inc_ident = '0;
    inc_dup   = '0;
    inc_evict = '0;
    base_n    = note_acc ? note_time : base_q;
    if (cand_take) begin
      inc_ident = CNTW'(1);
      if (dup_hit != '0) begin
        inc_dup = CNTW'(1);
      end else begin
        if (a_cnt == CNTW'(DEPTH)) begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            n_blk[i] = a_blk[i+1];
            n_rdy[i] = a_rdy[i+1];
          end
          n_cnt     = a_cnt - CNTW'(1);
          inc_evict = CNTW'(1);
        end
        for (int i = 0; i < DEPTH; i++) begin
          if (CNTW'(i) == n_cnt) begin
            n_blk[i] = cand_blk;
            n_rdy[i] = base_q + TW'(cand_delay);
          end
        end
        n_cnt = n_cnt + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        blk_q[i] <= '0;
        rdy_q[i] <= '0;
      end
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      blk_q  <= n_blk;
      rdy_q  <= n_rdy;
      cnt_q  <= n_cnt;
      base_q <= base_n;
    end
  end

  assign head_blk = blk_q[0];
  assign head_rdy = (cnt_q != '0) ? rdy_q[0] : '0;
  assign q_count  = cnt_q;
endmodule

// File: rtl/pfq_issue.sv
// Issue path: idle, head lookup, then issue or skip on the response.
module pfq_issue import pfq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_req,
  input  logic            note_acc,
  input  logic [CNTW-1:0] q_count,
  input  logic [AW-1:0]   head_blk,
  input  logic            rsp_cache,
  input  logic            rsp_mshr,
  output logic            lkup_req,
  output logic [AW-1:0]   lkup_blk,
  output logic            pop,
  output logic            issue_valid,
  output logic [AW-1:0]   issue_blk,
  output logic            issue_none,
  output logic [CNTW-1:0] inc_issued,
  output logic [CNTW-1:0] inc_skip
);
  pfq_state_e    st_q, st_n;
  logic [AW-1:0] tag_q, tag_n;
  logic          tag_en;

  always_comb begin
    st_n        = st_q;
    tag_n       = tag_q;
    tag_en      = 1'b0;
    lkup_req    = 1'b0;
    pop         = 1'b0;
    issue_valid = 1'b0;
    issue_none  = 1'b0;
    inc_issued  = '0;
    inc_skip    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (issue_req) begin
          if (q_count == '0) issue_none = 1'b1;
          else               st_n       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (q_count == '0) begin
          issue_none = 1'b1;
          st_n       = ST_IDLE;
        end else begin
          lkup_req = 1'b1;
          tag_n    = head_blk;
          tag_en   = 1'b1;
          st_n     = note_acc ? ST_LOOKUP : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (note_acc || (q_count == '0) || (head_blk != tag_q)) begin
          st_n = ST_LOOKUP;
        end else if (rsp_cache || rsp_mshr) begin
          pop      = 1'b1;
          inc_skip = CNTW'(1);
          if (q_count == CNTW'(1)) begin
            issue_none = 1'b1;
            st_n       = ST_IDLE;
          end else begin
            st_n = ST_LOOKUP;
          end
        end else begin
          pop         = 1'b1;
          issue_valid = 1'b1;
          inc_issued  = CNTW'(1);
          st_n        = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tag_q <= '0;
    end else begin
      st_q <= st_n;
      if (tag_en) tag_q <= tag_n;
    end
  end

  assign lkup_blk  = head_blk;
  assign issue_blk = head_blk;
endmodule

// File: rtl/pfq_manager.sv
module pfq_manager import pfq_pkg::*; #(
  parameter int AW        = 32,
  parameter int TW        = 32,
  parameter int DW        = 16,
  parameter int DEPTH     = 8,
  parameter int BLK_BYTES = 64,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_data_only,
  input  logic          cfg_serial_squash,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  input  logic [TW-1:0] miss_time,
  input  logic          miss_uncache,
  input  logic          miss_ifetch,
  input  logic          cand_valid,
  input  logic [AW-1:0] cand_addr,
  input  logic [DW-1:0] cand_delay,
  input  logic          issue_req,
  input  logic          lkup_in_cache,
  input  logic          lkup_in_mshr,
  output logic          lkup_req,
  output logic [AW-1:0] lkup_addr,
  output logic          issue_valid,
  output logic [AW-1:0] issue_addr,
  output logic          issue_none,
  output logic          pf_bus_req,
  output logic [TW-1:0] head_ready_time,
  output logic [CW-1:0] cnt_identified,
  output logic [CW-1:0] cnt_dup,
  output logic [CW-1:0] cnt_evicted,
  output logic [CW-1:0] cnt_cancelled,
  output logic [CW-1:0] cnt_squashed,
  output logic [CW-1:0] cnt_issued,
  output logic [CW-1:0] cnt_skipped
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << $clog2(BLK_BYTES);

  logic            note_acc, cand_take, pop;
  logic [AW-1:0]   miss_blk, cand_blk, head_blk;
  logic [CNTW-1:0] q_count;
  logic [CNTW-1:0] ev_inc [NUM_EV];
  logic [CW-1:0]   ev_cnt [NUM_EV];

  assign note_acc  = miss_valid && !miss_uncache && !(miss_ifetch && cfg_data_only);
  assign cand_take = cand_valid && !note_acc;
  assign miss_blk  = miss_addr & BLK_MASK;
  assign cand_blk  = cand_addr & BLK_MASK;

  pfq_store #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_squash (cfg_serial_squash),
    .note_acc   (note_acc),
    .note_blk   (miss_blk),
    .note_time  (miss_time),
    .cand_take  (cand_take),
    .cand_blk   (cand_blk),
    .cand_delay (cand_delay),
    .pop        (pop),
    .head_blk   (head_blk),
    .head_rdy   (head_ready_time),
    .q_count    (q_count),
    .inc_ident  (ev_inc[EV_IDENT]),
    .inc_dup    (ev_inc[EV_DUP]),
    .inc_evict  (ev_inc[EV_EVICT]),
    .inc_cancel (ev_inc[EV_CANCEL]),
    .inc_squash (ev_inc[EV_SQUASH])
  );

  pfq_issue #(.DEPTH(DEPTH), .AW(AW)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_req   (issue_req),
    .note_acc    (note_acc),
    .q_count     (q_count),
    .head_blk    (head_blk),
    .rsp_cache   (lkup_in_cache),
    .rsp_mshr    (lkup_in_mshr),
    .lkup_req    (lkup_req),
    .lkup_blk    (lkup_addr),
    .pop         (pop),
    .issue_valid (issue_valid),
    .issue_blk   (issue_addr),
    .issue_none  (issue_none),
    .inc_issued  (ev_inc[EV_ISSUED]),
    .inc_skip    (ev_inc[EV_SKIP])
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    pfq_evcnt #(.CW(CW), .IW(CNTW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[g]), .cnt(ev_cnt[g])
    );
  end

  assign pf_bus_req     = (q_count != '0);
  assign cnt_identified = ev_cnt[EV_IDENT];
  assign cnt_dup        = ev_cnt[EV_DUP];
  assign cnt_evicted    = ev_cnt[EV_EVICT];
  assign cnt_cancelled  = ev_cnt[EV_CANCEL];
  assign cnt_squashed   = ev_cnt[EV_SQUASH];
  assign cnt_issued     = ev_cnt[EV_ISSUED];
  assign cnt_skipped    = ev_cnt[EV_SKIP];
endmodule

// File: rtl/pfq_manager_chk.sv
module pfq_manager_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = 32,
  parameter int CW    = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_valid,
  input logic            miss_uncache,
  input logic            lkup_req,
  input logic            issue_valid,
  input logic            issue_none,
  input logic            pf_bus_req,
  input logic [TW-1:0]   head_ready_time,
  input logic [CW-1:0]   cnt_evicted,
  input logic [CW-1:0]   cnt_cancelled,
  input logic [CW-1:0]   cnt_squashed,
  input logic [CNTW-1:0] q_count
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && issue_none));  // R8

  AST_ISSUE_AFTER_LKUP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(lkup_req));  // R8

  AST_LKUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_req |-> pf_bus_req);  // R9

  AST_EMPTY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_bus_req |-> (head_ready_time == '0));  // R10

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNTW'(DEPTH));  // R7

  AST_EVICT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evicted != $past(cnt_evicted)) |-> ($past(q_count) == CNTW'(DEPTH)));  // R7

  AST_IGNORED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_uncache) |=> ($stable(cnt_cancelled) && $stable(cnt_squashed)));  // R2
endmodule

bind pfq_manager pfq_manager_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_valid      (miss_valid),
  .miss_uncache    (miss_uncache),
  .lkup_req        (lkup_req),
  .issue_valid     (issue_valid),
  .issue_none      (issue_none),
  .pf_bus_req      (pf_bus_req),
  .head_ready_time (head_ready_time),
  .cnt_evicted     (cnt_evicted),
  .cnt_cancelled   (cnt_cancelled),
  .cnt_squashed    (cnt_squashed),
  .q_count         (q_count)
);

// File: tb/sim_pfq_manager.sv
module sim_pfq_manager;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, TW = 16, DW = 8, DEPTH = 4, BLK = 16, CW = 8;

  logic clk, rst_n;
  logic cfg_data_only, cfg_serial_squash;
  logic miss_valid, miss_uncache, miss_ifetch;
  logic [AW-1:0] miss_addr;
  logic [TW-1:0] miss_time;
  logic cand_valid;
  logic [AW-1:0] cand_addr;
  logic [DW-1:0] cand_delay;
  logic issue_req, lkup_in_cache, lkup_in_mshr;
  logic lkup_req, issue_valid, issue_none, pf_bus_req;
  logic [AW-1:0] lkup_addr, issue_addr;
  logic [TW-1:0] head_ready_time;
  logic [CW-1:0] c_ident, c_dup, c_evict, c_cancel, c_squash, c_issued, c_skip;

  pfq_manager #(.AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .BLK_BYTES(BLK), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_data_only),
    .cfg_serial_squash(cfg_serial_squash), .miss_valid(miss_valid),
    .miss_addr(miss_addr), .miss_time(miss_time), .miss_uncache(miss_uncache),
    .miss_ifetch(miss_ifetch), .cand_valid(cand_valid), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .issue_req(issue_req), .lkup_in_cache(lkup_in_cache),
    .lkup_in_mshr(lkup_in_mshr), .lkup_req(lkup_req), .lkup_addr(lkup_addr),
    .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_none(issue_none),
    .pf_bus_req(pf_bus_req), .head_ready_time(head_ready_time),
    .cnt_identified(c_ident), .cnt_dup(c_dup), .cnt_evicted(c_evict),
    .cnt_cancelled(c_cancel), .cnt_squashed(c_squash), .cnt_issued(c_issued),
    .cnt_skipped(c_skip)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] cache_map = '0, mshr_map = '0;

  // reference queue built from the requirements
  int mq_blk[8], mq_rdy[8], mq_n = 0, base_t = 0;
  int e_cnt[7] = '{default: 0};

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // lookup responder: answers one cycle after the request
  always @(posedge clk) begin
    if (!rst_n) begin
      lkup_in_cache <= 1'b0;
      lkup_in_mshr  <= 1'b0;
    end else begin
      lkup_in_cache <= lkup_req && cache_map[lkup_addr[9:4]];
      lkup_in_mshr  <= lkup_req && mshr_map[lkup_addr[9:4]];
    end
  end

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void m_remove(int idx);
    for (int i = idx; i < mq_n - 1; i++) begin
      mq_blk[i] = mq_blk[i+1];
      mq_rdy[i] = mq_rdy[i+1];
    end
    mq_n--;
  endfunction

  function automatic void m_miss(int b, int t, bit unc, bit ifc);
    if (unc || (ifc && cfg_data_only)) return;
    for (int i = 0; i < mq_n; i++) begin
      if (mq_blk[i] == b) begin
        m_remove(i);
        e_cnt[3]++;
        break;
      end
    end
    if (cfg_serial_squash) begin
      while (mq_n > 0 && mq_rdy[mq_n-1] >= t) begin
        mq_n--;
        e_cnt[4]++;
      end
    end
    base_t = t;
  endfunction

  function automatic void m_cand(int b, int d);
    e_cnt[0]++;
    for (int i = 0; i < mq_n; i++) begin
      if (mq_blk[i] == b) begin
        e_cnt[1]++;
        return;
      end
    end
    if (mq_n == DEPTH) begin
      m_remove(0);
      e_cnt[2]++;
    end
    mq_blk[mq_n] = b;
    mq_rdy[mq_n] = (base_t + d) & 16'hFFFF;
    mq_n++;
  endfunction

  task automatic t_miss(int b, int off, int t, bit unc, bit ifc);
    miss_valid = 1'b1; miss_addr = AW'(b * BLK + off); miss_time = TW'(t);
    miss_uncache = unc; miss_ifetch = ifc;
    tick();
    miss_valid = 1'b0; miss_uncache = 1'b0; miss_ifetch = 1'b0;
    m_miss(b, t, unc, ifc);
  endtask

  task automatic t_cand(int b, int off, int d);
    cand_valid = 1'b1; cand_addr = AW'(b * BLK + off); cand_delay = DW'(d);
    tick();
    cand_valid = 1'b0;
    m_cand(b, d);
  endtask

  task automatic t_state(string req);
    check_eq({req, " bus_req (R9)"}, int'(pf_bus_req), int'(mq_n != 0));
    check_eq({req, " head_time (R10)"}, int'(head_ready_time), (mq_n != 0) ? mq_rdy[0] : 0);
    check_eq({req, " identified (R5)"}, int'(c_ident), e_cnt[0] & 255);
    check_eq({req, " dup (R5)"}, int'(c_dup), e_cnt[1] & 255);
    check_eq({req, " evicted (R7)"}, int'(c_evict), e_cnt[2] & 255);
    check_eq({req, " cancelled (R3)"}, int'(c_cancel), e_cnt[3] & 255);
    check_eq({req, " squashed (R4)"}, int'(c_squash), e_cnt[4] & 255);
    check_eq({req, " issued (R8)"}, int'(c_issued), e_cnt[5] & 255);
    check_eq({req, " skipped (R8)"}, int'(c_skip), e_cnt[6] & 255);
  endtask

  task automatic t_issue(string req);
    int exp_valid = 0, exp_blk = 0, exam = 0, got_valid = 0, got_none = 0;
    int got_addr = 0, lk = 0;
    while (mq_n > 0) begin
      int b = mq_blk[0];
      m_remove(0);
      exam++;
      if (cache_map[b] || mshr_map[b]) begin
        e_cnt[6]++;
      end else begin
        e_cnt[5]++;
        exp_valid = 1;
        exp_blk = b;
        break;
      end
    end
    issue_req = 1'b1;
    #1;
    if (issue_none) begin
      got_none = 1;
      tick();
      issue_req = 1'b0;
    end else begin
      tick();
      issue_req = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (lkup_req) lk++;
        if (issue_valid) begin got_valid = 1; got_addr = int'(issue_addr); end
        if (issue_none) got_none = 1;
        tick();
        if (got_valid || got_none) break;
      end
    end
    check_eq({req, " issue_valid (R8)"}, got_valid, exp_valid);
    check_eq({req, " issue_none (R8)"}, got_none, 1 - exp_valid);
    if (exp_valid != 0) check_eq({req, " issue_addr (R1/R12)"}, got_addr, exp_blk * BLK);
    check_eq({req, " lookups (R8)"}, lk, exam);
    t_state(req);
  endtask

  task automatic t_drain(string req);
    while (mq_n > 0) t_issue(req);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", wd);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_data_only = 1'b0; cfg_serial_squash = 1'b0;
    miss_valid = 1'b0; miss_addr = '0; miss_time = '0; miss_uncache = 1'b0; miss_ifetch = 1'b0;
    cand_valid = 1'b0; cand_addr = '0; cand_delay = '0; issue_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    t_state("reset");
    check_eq("reset issue_valid (R8)", int'(issue_valid), 0);
    t_issue("R8 empty");

    // R2: miss filter across all flag combinations
    for (int d = 0; d < 2; d++) begin
      for (int u = 0; u < 2; u++) begin
        for (int f = 0; f < 2; f++) begin
          cfg_data_only = d[0];
          t_miss(60, 0, 100, 1'b0, 1'b0);
          t_cand(1, 0, 5);
          t_cand(2, 0, 7);
          t_miss(1, 3, 200, u[0], f[0]);
          t_cand(3, 0, 1); // ready time shows whether the base time moved
          t_state("R2");
          t_drain("R2");
        end
      end
    end
    cfg_data_only = 1'b0;

    // R5 / R1: duplicates at different offsets in the same block
    t_miss(50, 0, 10, 1'b0, 1'b0);
    t_cand(3, 0, 1);
    t_cand(3, 15, 2);
    t_cand(4, 8, 3);
    t_cand(3, 7, 4);
    t_cand(4, 0, 5);
    t_state("R5");
    t_drain("R12");

    // R6 / R7: fill sweep through overflow
    for (int n = 1; n <= 7; n++) begin
      t_miss(51, 0, 1000 + n, 1'b0, 1'b0);
      for (int k = 0; k < n; k++) t_cand(10 + k, k, k * 3);
      t_state("R6/R7");
      t_drain("R12");
    end

    // R3: cancel each position
    for (int p = 0; p < 4; p++) begin
      t_miss(52, 0, 300, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) t_cand(20 + k, 0, k + 1);
      t_miss(20 + p, 9, 310, 1'b0, 1'b0);
      t_state("R3");
      t_drain("R3");
    end

    // R4: squash threshold sweep, odd steps also cancel an entry
    cfg_serial_squash = 1'b1;
    for (int t = 0; t <= 12; t++) begin
      t_miss(55, 0, 100, 1'b0, 1'b0);
      t_cand(20, 0, 5);
      t_cand(21, 0, 2);
      t_cand(22, 0, 9);
      t_cand(23, 0, 4);
      t_miss(((t % 2) != 0) ? 21 : 56, 0, 100 + t, 1'b0, 1'b0);
      t_state("R4");
      t_drain("R4");
    end
    cfg_serial_squash = 1'b0;

    // R8: every hit pattern, cache and pending sources
    for (int kind = 0; kind < 2; kind++) begin
      for (int m = 0; m < 16; m++) begin
        t_miss(57, 0, 40, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) t_cand(30 + k, 0, k);
        for (int k = 0; k < 4; k++) begin
          if (m[k]) begin
            if (kind == 0) cache_map[30 + k] = 1'b1;
            else           mshr_map[30 + k] = 1'b1;
          end
        end
        while (mq_n > 0) t_issue("R8");
        t_issue("R8 empty");
        cache_map = '0;
        mshr_map = '0;
      end
    end

    // R11: miss during lookup restarts; coincident candidate dropped
    t_miss(58, 0, 0, 1'b0, 1'b0);
    t_cand(40, 0, 3);
    t_cand(41, 0, 6);
    t_cand(42, 0, 9);
    issue_req = 1'b1;
    tick();
    issue_req = 1'b0;
    check_eq("R11 first lookup", int'(lkup_req), 1);
    check_eq("R11 first lookup addr", int'(lkup_addr), 40 * BLK);
    miss_valid = 1'b1; miss_addr = AW'(40 * BLK + 2); miss_time = 5;
    cand_valid = 1'b1; cand_addr = AW'(43 * BLK); cand_delay = 1;
    tick();
    miss_valid = 1'b0; cand_valid = 1'b0;
    m_miss(40, 5, 1'b0, 1'b0);
    check_eq("R11 restarted lookup", int'(lkup_req), 1);
    check_eq("R11 restarted lookup addr", int'(lkup_addr), 41 * BLK);
    tick();
    check_eq("R11 issue after restart", int'(issue_valid), 1);
    check_eq("R11 issue addr", int'(issue_addr), 41 * BLK);
    m_remove(0);
    e_cnt[5]++;
    tick();
    t_state("R11");
    t_drain("R11");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule